// File: doc/BRIEF.md
# Address-space-tagged fully associative translation buffer

This block holds a parameterised number of page translations, each tagged with a virtual page number and an address space number. A lookup hits when the page number matches and the entry is either marked global or belongs to the requesting address space. On a hit the block returns the physical page number, the stored address space number, the global flag, per-mode read and write permission masks, and the two fault-on-access bits. Fault decisions and the page-table walk sit outside the block; the lookup result is combinational and all updates take effect at the clock edge.

New translations are written into the slot named by a round-robin replacement pointer, whatever that slot holds. Three kinds of invalidation are supported: wipe everything, drop every non-global entry, and drop the entries that match one virtual page under the lookup rule. A peek port shows the slot under the replacement pointer and can step the pointer, so software can see which slot is next to be replaced.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits in the same cycle when some entry is valid, its page tag equals `lk_vpn_i`, and its global flag is set or its address space number equals `lk_asn_i`; on a miss every lookup data output is zero.
- R2: An accepted insert writes the slot at the replacement pointer and advances the pointer by one, wrapping from ENTRIES-1 to 0.
- R3: The inserted entry takes as its tag bits [VA_W-1:PAGE_BITS] of `ins_va_i`, is marked valid, and stores all supplied fields; it is visible to lookups from the next cycle.
- R4: A wipe (`flush_all_i`) clears every entry, all fields to zero, and resets the replacement pointer to 0.
- R5: A local flush (`flush_local_i`) invalidates every entry whose global flag is clear and leaves global entries valid.
- R6: A page flush (`flush_va_i`) invalidates every valid entry whose tag equals bits [VA_W-1:PAGE_BITS] of `flush_addr_i` and that is global or whose address space number equals `flush_asn_i`; other entries are kept.
- R7: When several entries match a lookup, the lowest slot index is reported on `lk_idx_o` and its fields are returned.
- R8: The peek outputs show the slot at the replacement pointer; `peek_adv_i` advances the pointer by one (with wrap) unless a wipe happens in the same cycle, and an accepted insert together with `peek_adv_i` still advances by exactly one.
- R9: Commands in the same cycle are resolved by priority wipe, local flush, page flush, insert; a lower-priority command is ignored, so an ignored insert neither writes nor moves the pointer.
- R10: After reset every entry is invalid and zero, the pointer is 0 and lookups miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_vpn_i | input | VA_W-PAGE_BITS | Lookup virtual page number |
| lk_asn_i | input | ASN_W | Lookup address space number |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IDX_W | Index of the hitting slot |
| lk_ppn_o | output | PPN_W | Physical page number of the hit |
| lk_asn_o | output | ASN_W | Stored address space number of the hit |
| lk_glob_o | output | 1 | Global flag of the hit |
| lk_rd_perm_o | output | 4 | Read permission per privilege mode |
| lk_wr_perm_o | output | 4 | Write permission per privilege mode |
| lk_frd_o | output | 1 | Fault-on-read bit |
| lk_fwr_o | output | 1 | Fault-on-write bit |
| ins_valid_i | input | 1 | Insert request |
| ins_va_i | input | VA_W | Virtual address of the new entry |
| ins_ppn_i | input | PPN_W | Physical page number of the new entry |
| ins_asn_i | input | ASN_W | Address space number of the new entry |
| ins_glob_i | input | 1 | Global flag of the new entry |
| ins_rd_perm_i | input | 4 | Read permission mask of the new entry |
| ins_wr_perm_i | input | 4 | Write permission mask of the new entry |
| ins_frd_i | input | 1 | Fault-on-read bit of the new entry |
| ins_fwr_i | input | 1 | Fault-on-write bit of the new entry |
| flush_all_i | input | 1 | Wipe all entries and reset the pointer |
| flush_local_i | input | 1 | Invalidate all non-global entries |
| flush_va_i | input | 1 | Invalidate entries matching one page |
| flush_addr_i | input | VA_W | Virtual address for the page flush |
| flush_asn_i | input | ASN_W | Address space number for the page flush |
| peek_adv_i | input | 1 | Advance the replacement pointer |
| peek_ptr_o | output | IDX_W | Replacement pointer |
| peek_valid_o | output | 1 | Valid bit of the slot at the pointer |
| peek_vpn_o | output | VA_W-PAGE_BITS | Tag of the slot at the pointer |
| peek_ppn_o | output | PPN_W | Physical page number of the slot at the pointer |
| peek_asn_o | output | ASN_W | Address space number of the slot at the pointer |
| peek_glob_o | output | 1 | Global flag of the slot at the pointer |

## Verification
Lookup and peek outputs are combinational on the stored state, so they are due in the same cycle as the lookup inputs, while every insert, flush and pointer step is due one cycle later, right after the rising edge that captures it. The bench changes inputs on the falling edge, compares all lookup and peek outputs against a behavioural model shortly after, and only then lets the rising edge pass and applies the same command to the model. A directed phase sweeps every page and address-space pair after each kind of command, and a long mixed phase draws commands from a small page range so that duplicate matches, wraps and same-cycle command collisions recur.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned NUM_MODES = 4;
  typedef logic [NUM_MODES-1:0] perm_t;
  typedef enum logic [2:0] {
    OP_IDLE, OP_INSERT, OP_FLUSH_VA, OP_FLUSH_LOCAL, OP_FLUSH_ALL
  } tlb_op_e;
endpackage

// File: rtl/tlb_op_arb.sv
module tlb_op_arb import tlb_pkg::*; (
  input  logic    ins_valid_i,
  input  logic    flush_all_i,
  input  logic    flush_local_i,
  input  logic    flush_va_i,
  input  logic    peek_adv_i,
  output tlb_op_e op_o,
  output logic    step_o
);
  always_comb begin
    if (flush_all_i)        op_o = OP_FLUSH_ALL;
    else if (flush_local_i) op_o = OP_FLUSH_LOCAL;
    else if (flush_va_i)    op_o = OP_FLUSH_VA;
    else if (ins_valid_i)   op_o = OP_INSERT;
    else                    op_o = OP_IDLE;
  end
  // one step at most, even with insert and peek advance together
  assign step_o = (op_o == OP_INSERT) || (peek_adv_i && op_o != OP_FLUSH_ALL);
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (clear_i) ptr_o <= '0;
    else if (step_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/tlb_slot.sv
module tlb_slot import tlb_pkg::*; #(
  parameter int unsigned VPN_W = 12,
  parameter int unsigned PPN_W = 12,
  parameter int unsigned ASN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tlb_op_e          op_i,
  input  logic             sel_i,
  input  logic [VPN_W-1:0] w_vpn_i,
  input  logic [PPN_W-1:0] w_ppn_i,
  input  logic [ASN_W-1:0] w_asn_i,
  input  logic             w_glob_i,
  input  perm_t            w_rd_i,
  input  perm_t            w_wr_i,
  input  logic             w_frd_i,
  input  logic             w_fwr_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [ASN_W-1:0] lk_asn_i,
  input  logic [VPN_W-1:0] fl_vpn_i,
  input  logic [ASN_W-1:0] fl_asn_i,
  output logic             lk_match_o,
  output logic             valid_o,
  output logic [VPN_W-1:0] vpn_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [ASN_W-1:0] asn_o,
  output logic             glob_o,
  output perm_t            rd_o,
  output perm_t            wr_o,
  output logic             frd_o,
  output logic             fwr_o
);
  logic fl_match;
  assign lk_match_o = valid_o && (vpn_o == lk_vpn_i) && (glob_o || asn_o == lk_asn_i);
  assign fl_match   = valid_o && (vpn_o == fl_vpn_i) && (glob_o || asn_o == fl_asn_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; vpn_o <= '0; ppn_o <= '0; asn_o <= '0;
      glob_o <= 1'b0; rd_o <= '0; wr_o <= '0; frd_o <= 1'b0; fwr_o <= 1'b0;
    end else begin
      unique case (op_i)
        OP_FLUSH_ALL: begin
          valid_o <= 1'b0; vpn_o <= '0; ppn_o <= '0; asn_o <= '0;
          glob_o <= 1'b0; rd_o <= '0; wr_o <= '0; frd_o <= 1'b0; fwr_o <= 1'b0;
        end
        OP_FLUSH_LOCAL: if (!glob_o) valid_o <= 1'b0;
        OP_FLUSH_VA:    if (fl_match) valid_o <= 1'b0;
        OP_INSERT: if (sel_i) begin
          valid_o <= 1'b1; vpn_o <= w_vpn_i; ppn_o <= w_ppn_i; asn_o <= w_asn_i;
          glob_o <= w_glob_i; rd_o <= w_rd_i; wr_o <= w_wr_i;
          frd_o <= w_frd_i; fwr_o <= w_fwr_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] match_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  assign hit_o = |match_i;
  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match_i[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb import tlb_pkg::*; #(
  parameter int unsigned ENTRIES   = 8,
  parameter int unsigned VA_W      = 20,
  parameter int unsigned PAGE_BITS = 8,
  parameter int unsigned PPN_W     = 12,
  parameter int unsigned ASN_W     = 4,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
  localparam int unsigned IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [VPN_W-1:0]     lk_vpn_i,
  input  logic [ASN_W-1:0]     lk_asn_i,
  output logic                 lk_hit_o,
  output logic [IDX_W-1:0]     lk_idx_o,
  output logic [PPN_W-1:0]     lk_ppn_o,
  output logic [ASN_W-1:0]     lk_asn_o,
  output logic                 lk_glob_o,
  output logic [NUM_MODES-1:0] lk_rd_perm_o,
  output logic [NUM_MODES-1:0] lk_wr_perm_o,
  output logic                 lk_frd_o,
  output logic                 lk_fwr_o,
  input  logic                 ins_valid_i,
  input  logic [VA_W-1:0]      ins_va_i,
  input  logic [PPN_W-1:0]     ins_ppn_i,
  input  logic [ASN_W-1:0]     ins_asn_i,
  input  logic                 ins_glob_i,
  input  logic [NUM_MODES-1:0] ins_rd_perm_i,
  input  logic [NUM_MODES-1:0] ins_wr_perm_i,
  input  logic                 ins_frd_i,
  input  logic                 ins_fwr_i,
  input  logic                 flush_all_i,
  input  logic                 flush_local_i,
  input  logic                 flush_va_i,
  input  logic [VA_W-1:0]      flush_addr_i,
  input  logic [ASN_W-1:0]     flush_asn_i,
  input  logic                 peek_adv_i,
  output logic [IDX_W-1:0]     peek_ptr_o,
  output logic                 peek_valid_o,
  output logic [VPN_W-1:0]     peek_vpn_o,
  output logic [PPN_W-1:0]     peek_ppn_o,
  output logic [ASN_W-1:0]     peek_asn_o,
  output logic                 peek_glob_o
);
  tlb_op_e          op;
  logic             step;
  logic [IDX_W-1:0] ptr;

  logic [ENTRIES-1:0] e_match, e_valid, e_glob, e_frd, e_fwr;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [ASN_W-1:0]   e_asn [ENTRIES];
  perm_t              e_rd  [ENTRIES];
  perm_t              e_wr  [ENTRIES];

  tlb_op_arb u_arb (
    .ins_valid_i(ins_valid_i), .flush_all_i(flush_all_i),
    .flush_local_i(flush_local_i), .flush_va_i(flush_va_i),
    .peek_adv_i(peek_adv_i), .op_o(op), .step_o(step)
  );

  tlb_rr_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(op == OP_FLUSH_ALL),
    .step_i(step), .ptr_o(ptr)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W)) u_slot (
      .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op),
      .sel_i(ptr == IDX_W'(g)),
      .w_vpn_i(ins_va_i[VA_W-1:PAGE_BITS]), .w_ppn_i(ins_ppn_i),
      .w_asn_i(ins_asn_i), .w_glob_i(ins_glob_i),
      .w_rd_i(ins_rd_perm_i), .w_wr_i(ins_wr_perm_i),
      .w_frd_i(ins_frd_i), .w_fwr_i(ins_fwr_i),
      .lk_vpn_i(lk_vpn_i), .lk_asn_i(lk_asn_i),
      .fl_vpn_i(flush_addr_i[VA_W-1:PAGE_BITS]), .fl_asn_i(flush_asn_i),
      .lk_match_o(e_match[g]), .valid_o(e_valid[g]),
      .vpn_o(e_vpn[g]), .ppn_o(e_ppn[g]), .asn_o(e_asn[g]),
      .glob_o(e_glob[g]), .rd_o(e_rd[g]), .wr_o(e_wr[g]),
      .frd_o(e_frd[g]), .fwr_o(e_fwr[g])
    );
  end

  tlb_first_hit #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sel (
    .match_i(e_match), .hit_o(lk_hit_o), .idx_o(lk_idx_o)
  );

  always_comb begin
    lk_ppn_o = '0; lk_asn_o = '0; lk_glob_o = 1'b0;
    lk_rd_perm_o = '0; lk_wr_perm_o = '0; lk_frd_o = 1'b0; lk_fwr_o = 1'b0;
    if (lk_hit_o) begin
      lk_ppn_o     = e_ppn[lk_idx_o];
      lk_asn_o     = e_asn[lk_idx_o];
      lk_glob_o    = e_glob[lk_idx_o];
      lk_rd_perm_o = e_rd[lk_idx_o];
      lk_wr_perm_o = e_wr[lk_idx_o];
      lk_frd_o     = e_frd[lk_idx_o];
      lk_fwr_o     = e_fwr[lk_idx_o];
    end
  end

  assign peek_ptr_o   = ptr;
  assign peek_valid_o = e_valid[ptr];
  assign peek_vpn_o   = e_vpn[ptr];
  assign peek_ppn_o   = e_ppn[ptr];
  assign peek_asn_o   = e_asn[ptr];
  assign peek_glob_o  = e_glob[ptr];
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ins_valid_i,
  input logic             flush_all_i,
  input logic             flush_local_i,
  input logic             flush_va_i,
  input logic             peek_adv_i,
  input logic             lk_hit_o,
  input logic             peek_valid_o,
  input logic [IDX_W-1:0] peek_ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  AST_WIPE_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (!lk_hit_o && !peek_valid_o)); // R4
  AST_WIPE_PTR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (peek_ptr_o == '0)); // R4
  AST_INSERT_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !flush_all_i && !flush_local_i && !flush_va_i) |=>
    (peek_ptr_o == (($past(peek_ptr_o) == LAST) ? '0 : $past(peek_ptr_o) + 1'b1))); // R2
  AST_PTR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_valid_i && !peek_adv_i && !flush_all_i) |=> $stable(peek_ptr_o)); // R8
  AST_LOSER_INSERT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && (flush_local_i || flush_va_i) && !flush_all_i && !peek_adv_i)
    |=> $stable(peek_ptr_o)); // R9
endmodule

bind asid_tlb tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ins_valid_i(ins_valid_i),
  .flush_all_i(flush_all_i), .flush_local_i(flush_local_i),
  .flush_va_i(flush_va_i), .peek_adv_i(peek_adv_i), .lk_hit_o(lk_hit_o),
  .peek_valid_o(peek_valid_o), .peek_ptr_o(peek_ptr_o)
);

// File: tb/sim_asid_tlb.sv
module sim_asid_tlb;
  localparam int CLK_P = 10;
  localparam int E = 8, VA_W = 20, PB = 8, PPN_W = 12, ASN_W = 4;
  localparam int VPN_W = VA_W - PB, IDX_W = 3;

  logic clk_i = 0, rst_ni = 0;
  always #(CLK_P/2) clk_i = ~clk_i;

  logic [VPN_W-1:0] lk_vpn_i = '0;
  logic [ASN_W-1:0] lk_asn_i = '0;
  logic lk_hit_o, lk_glob_o, lk_frd_o, lk_fwr_o;
  logic [IDX_W-1:0] lk_idx_o, peek_ptr_o;
  logic [PPN_W-1:0] lk_ppn_o, peek_ppn_o;
  logic [ASN_W-1:0] lk_asn_o, peek_asn_o;
  logic [3:0] lk_rd_perm_o, lk_wr_perm_o;
  logic ins_valid_i = 0, ins_glob_i = 0, ins_frd_i = 0, ins_fwr_i = 0;
  logic [VA_W-1:0] ins_va_i = '0, flush_addr_i = '0;
  logic [PPN_W-1:0] ins_ppn_i = '0;
  logic [ASN_W-1:0] ins_asn_i = '0, flush_asn_i = '0;
  logic [3:0] ins_rd_perm_i = '0, ins_wr_perm_i = '0;
  logic flush_all_i = 0, flush_local_i = 0, flush_va_i = 0, peek_adv_i = 0;
  logic peek_valid_o, peek_glob_o;
  logic [VPN_W-1:0] peek_vpn_o;

  asid_tlb u0 (.*);

  int m_v[E], m_vpn[E], m_ppn[E], m_asn[E], m_g[E], m_rd[E], m_wr[E], m_frd[E], m_fwr[E];
  int m_ptr = 0;
  int n_vec = 0, n_bad = 0;
  string phase = "R10";
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
    end
  endtask

  function automatic int exp_idx();
    for (int i = 0; i < E; i++)
      if (m_v[i] != 0 && m_vpn[i] == int'(lk_vpn_i) && (m_g[i] != 0 || m_asn[i] == int'(lk_asn_i)))
        return i;
    return -1;
  endfunction

  task automatic compare();
    int k;
    k = exp_idx();
    chk("R1 hit", int'(lk_hit_o), (k >= 0) ? 1 : 0);
    if (k >= 0) chk("R7 idx", int'(lk_idx_o), k);
    chk("R3 ppn", int'(lk_ppn_o), (k >= 0) ? m_ppn[k] : 0);
    chk("R3 asn", int'(lk_asn_o), (k >= 0) ? m_asn[k] : 0);
    chk("R3 glob", int'(lk_glob_o), (k >= 0) ? m_g[k] : 0);
    chk("R3 perms", int'({lk_rd_perm_o, lk_wr_perm_o, lk_frd_o, lk_fwr_o}),
        (k >= 0) ? ((m_rd[k] << 6) | (m_wr[k] << 2) | (m_frd[k] << 1) | m_fwr[k]) : 0);
    chk("R2 ptr", int'(peek_ptr_o), m_ptr);
    chk("R8 peek valid", int'(peek_valid_o), m_v[m_ptr]);
    chk("R8 peek vpn", int'(peek_vpn_o), m_vpn[m_ptr]);
    chk("R8 peek ppn", int'(peek_ppn_o), m_ppn[m_ptr]);
    chk("R8 peek asn/glob", int'({peek_asn_o, peek_glob_o}), (m_asn[m_ptr] << 1) | m_g[m_ptr]);
  endtask

  // model: priority wipe > local > page > insert
  task automatic update_model();
    bit ins_ok;
    int fv;
    ins_ok = ins_valid_i && !flush_all_i && !flush_local_i && !flush_va_i;
    fv = int'(flush_addr_i[VA_W-1:PB]);
    if (flush_all_i) begin
      for (int i = 0; i < E; i++) begin
        m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_asn[i] = 0; m_g[i] = 0;
        m_rd[i] = 0; m_wr[i] = 0; m_frd[i] = 0; m_fwr[i] = 0;
      end
    end else if (flush_local_i) begin
      for (int i = 0; i < E; i++) if (m_g[i] == 0) m_v[i] = 0;
    end else if (flush_va_i) begin
      for (int i = 0; i < E; i++)
        if (m_v[i] != 0 && m_vpn[i] == fv && (m_g[i] != 0 || m_asn[i] == int'(flush_asn_i))) m_v[i] = 0;
    end else if (ins_ok) begin
      m_v[m_ptr] = 1; m_vpn[m_ptr] = int'(ins_va_i[VA_W-1:PB]); m_ppn[m_ptr] = int'(ins_ppn_i);
      m_asn[m_ptr] = int'(ins_asn_i); m_g[m_ptr] = int'(ins_glob_i);
      m_rd[m_ptr] = int'(ins_rd_perm_i); m_wr[m_ptr] = int'(ins_wr_perm_i);
      m_frd[m_ptr] = int'(ins_frd_i); m_fwr[m_ptr] = int'(ins_fwr_i);
    end
    if (flush_all_i) m_ptr = 0;
    else if (ins_ok || peek_adv_i) m_ptr = (m_ptr + 1) % E;
  endtask

  task automatic step();
    #2 compare();
    @(posedge clk_i);
    update_model();
    @(negedge clk_i);
  endtask

  task automatic clear_cmds();
    ins_valid_i = 0; flush_all_i = 0; flush_local_i = 0; flush_va_i = 0; peek_adv_i = 0;
  endtask

  task automatic do_insert(int vpn, int ppn, int asn, int g, int rd, int wr);
    ins_valid_i = 1; ins_va_i = VA_W'((vpn << PB) | 8'h5A); ins_ppn_i = PPN_W'(ppn);
    ins_asn_i = ASN_W'(asn); ins_glob_i = g[0]; ins_rd_perm_i = rd[3:0]; ins_wr_perm_i = wr[3:0];
    ins_frd_i = rd[0]; ins_fwr_i = wr[1];
    step(); clear_cmds();
  endtask

  task automatic sweep();
    for (int v = 0; v < 6; v++)
      for (int a = 0; a < 3; a++) begin
        lk_vpn_i = VPN_W'(v); lk_asn_i = ASN_W'(a); step();
      end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < E; i++) begin
      m_v[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_asn[i] = 0; m_g[i] = 0;
      m_rd[i] = 0; m_wr[i] = 0; m_frd[i] = 0; m_fwr[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk("R10 hit", int'(lk_hit_o), 0);
    chk("R10 ptr", int'(peek_ptr_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    sweep();

    phase = "R3";
    do_insert(1, 12'h101, 1, 0, 4'b0011, 4'b0001);
    do_insert(2, 12'h202, 2, 0, 4'b1111, 4'b0110);
    do_insert(3, 12'h303, 0, 1, 4'b0101, 4'b1010);
    do_insert(1, 12'h111, 2, 0, 4'b1000, 4'b0100);
    sweep();

    phase = "R7";
    do_insert(2, 12'h222, 2, 0, 4'b0001, 4'b0001);
    do_insert(4, 12'h404, 1, 1, 4'b0010, 4'b0010);
    sweep();

    phase = "R2";
    do_insert(5, 12'h505, 0, 0, 4'b0100, 4'b0000);
    do_insert(0, 12'h0AA, 1, 0, 4'b1100, 4'b0011);
    do_insert(2, 12'h2F0, 1, 0, 4'b0111, 4'b0111); // wraps into slot 0
    sweep();

    phase = "R6";
    flush_va_i = 1; flush_addr_i = VA_W'((1 << PB) | 3); flush_asn_i = 4'd1; step(); clear_cmds();
    flush_va_i = 1; flush_addr_i = VA_W'(3 << PB); flush_asn_i = 4'd2; step(); clear_cmds();
    sweep();

    phase = "R9";
    ins_valid_i = 1; ins_va_i = VA_W'(5 << PB); ins_ppn_i = 12'hEEE; flush_local_i = 1;
    step(); clear_cmds();
    ins_valid_i = 1; ins_va_i = VA_W'(4 << PB); flush_va_i = 1; flush_addr_i = '0;
    flush_asn_i = 4'd3; step(); clear_cmds();
    sweep();

    phase = "R5";
    do_insert(3, 12'h333, 2, 1, 4'b1111, 4'b1111);
    do_insert(1, 12'h199, 0, 0, 4'b0001, 4'b0001);
    flush_local_i = 1; step(); clear_cmds();
    sweep();

    phase = "R8";
    for (int i = 0; i < 10; i++) begin peek_adv_i = 1; step(); end
    peek_adv_i = 1; do_insert(5, 12'h5C5, 1, 0, 4'b0010, 4'b0000);
    clear_cmds(); step();

    phase = "R4";
    ins_valid_i = 1; peek_adv_i = 1; flush_all_i = 1; ins_va_i = VA_W'(2 << PB);
    step(); clear_cmds();
    sweep();

    phase = "R1";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      clear_cmds();
      lk_vpn_i = VPN_W'($urandom_range(0, 5)); lk_asn_i = ASN_W'($urandom_range(0, 2));
      ins_valid_i = (r < 45); peek_adv_i = (r % 7 == 0);
      flush_va_i = (r >= 45 && r < 55); flush_local_i = (r >= 55 && r < 59);
      flush_all_i = (r == 99);
      ins_va_i = VA_W'(($urandom_range(0, 5) << PB) | $urandom_range(0, 255));
      ins_ppn_i = PPN_W'($urandom); ins_asn_i = ASN_W'($urandom_range(0, 2));
      ins_glob_i = ($urandom_range(0, 3) == 0); ins_rd_perm_i = 4'($urandom);
      ins_wr_perm_i = 4'($urandom); ins_frd_i = 1'($urandom); ins_fwr_i = 1'($urandom);
      flush_addr_i = VA_W'($urandom_range(0, 5) << PB); flush_asn_i = ASN_W'($urandom_range(0, 2));
      step();
    end
    clear_cmds();
    sweep();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule